// File: doc/BRIEF.md
# One-Shot Down-Counting Interval Timer

This block is a 16-bit interval timer that a processor drives over a small byte-wide register port. Software first writes the low half of the start value into a holding latch. Writing the high half then copies both halves into the counter and starts a single timeout. The counter steps down once for each enable tick. On the first pass through zero it sets a timeout flag and wraps to all ones, then keeps counting down without end.

The flag records the timeout whether or not the interrupt is enabled. A separate enable bit decides whether the flag drives the interrupt output. Software can clear the flag in three ways: by reading the low counter byte, by writing a one to the flag bit, or by loading a new start value. A load also re-arms the timer for one more timeout. Later wraps of the free-running counter never set the flag again.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the counter reads 0, the flag (register 2, bit 0) reads 0, the enable (register 3, bit 0) reads 0, irq_o is low, and the timer is disarmed, so the counter wrapping through zero does not set the flag.
- R2: A write to register 0 stores the low byte in a latch and leaves the counter unchanged. A write to register 1 loads {written byte, latched byte} into the counter on that clock edge, clears the flag and arms the timer.
- R3: On the first tick after a load the counter holds its loaded value. Each later tick lowers it by one. With no tick it does not change. A tick in the same cycle as a load is ignored, and the hold still applies to the next tick.
- R4: The flag sets on the tick that steps an armed counter down from 0. After loading N, the flag is therefore first set by tick N+2.
- R5: The step down from 0 wraps the counter to 16'hFFFF, and counting continues from there.
- R6: After a timeout the flag is not set again, however many times the counter wraps, until the next load re-arms the timer.
- R7: The flag sets even while the enable is 0, and stays set until one of the clears in R2 or R9 happens.
- R8: irq_o is high exactly when the flag and the enable are both 1. Register 2 bit 7 shows irq_o. A write to register 3 with bit 0 set changes the enable to the value of written bit 7 (1 sets it, 0 clears it). With bit 0 clear the write has no effect.
- R9: A read strobe (rd_en) on register 0 clears the flag. A write to register 2 with bit 0 = 1 clears the flag. With bit 0 = 0 the write leaves the flag unchanged. If a clear and a timeout fall in the same cycle, the timeout wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable, one pulse per timer step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for its side effects) |
| addr | input | 2 | Register select: 0 counter low, 1 counter high, 2 flag, 3 enable |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with the default byte width of 8, which gives a 16-bit counter. At that width a full wrap takes 65536 ticks. The bench runs that many ticks after a timeout, so the no-second-flag rule is checked across a complete pass through zero. Table vectors cover the edge cases of the count formula: a start value of 0 or 1, the hold tick, and the tick exactly one before and one at the timeout.

// File: rtl/ost_pkg.sv
package ost_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_FLAG   = 2'd2,
        REG_ENA    = 2'd3
    } ost_reg_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_flag;
        logic wr_ena;
        logic rd_lo;
    } ost_access_t;

    localparam int FLAG_BIT     = 0;
    localparam int ENA_SEL_BIT  = 0;
    localparam int ENA_MODE_BIT = 7;
    localparam int IRQ_VIEW_BIT = 7;

    function automatic ost_access_t ost_decode(input logic wr, input logic rd,
                                               input ost_reg_e sel);
        ost_access_t a;
        a.wr_lo   = wr && (sel == REG_CNT_LO);
        a.wr_hi   = wr && (sel == REG_CNT_HI);
        a.wr_flag = wr && (sel == REG_FLAG);
        a.wr_ena  = wr && (sel == REG_ENA);
        a.rd_lo   = rd && (sel == REG_CNT_LO);
        return a;
    endfunction

endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= ZERO;
            hold_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            hold_q  <= 1'b1;
            armed_q <= 1'b1;
        end else if (tick) begin
            if (hold_q) begin
                hold_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ZERO) armed_q <= 1'b0;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign timeout_o = tick && !load && !hold_q && armed_q && (cnt_q == ZERO);

    // R2: a load places the start value in the counter
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));

    // R3: the first tick after a load leaves the counter where it is
    p_hold_first_r3: assert property (@(posedge clk) disable iff (rst)
        hold_q && tick && !load |=> $stable(cnt_q));

    // R3: without a tick or a load the counter is frozen
    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !tick && !load |=> $stable(cnt_q));

    // R5: stepping down from zero lands on all ones
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        tick && !load && !hold_q && (cnt_q == ZERO) |=> (&cnt_q));

    // R6: once fired, no further timeout until a load
    p_single_fire_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !armed_q);

endmodule

// File: rtl/ost_irq_ctrl.sv
module ost_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ena_wr,
    input  logic ena_val,
    output logic flag_o,
    output logic ena_o,
    output logic irq_o
);
    logic flag_q;
    logic ena_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= 1'b0;
        end else if (ena_wr) begin
            ena_q <= ena_val;
        end
    end

    assign flag_o = flag_q;
    assign ena_o  = ena_q;
    assign irq_o  = flag_q && ena_q;

    // R7: the flag stays set until something clears it
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr_i |=> flag_q);

    // R9: a clear with no coincident timeout empties the flag
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_i && !set_i |=> !flag_q);

    // R8: the enable changes only through its own write
    p_ena_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !ena_wr |=> $stable(ena_q));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import ost_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_o
);
    localparam int CNT_W = 2 * BYTE_W;

    ost_access_t      acc;
    logic [BYTE_W-1:0] lo_latch_q;
    logic [CNT_W-1:0]  cnt;
    logic              timeout;
    logic              flag;
    logic              ena;
    logic              irq;
    logic              flag_clr;

    assign acc = ost_decode(wr_en, rd_en, ost_reg_e'(addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_latch_q <= '0;
        end else if (acc.wr_lo) begin
            lo_latch_q <= wdata;
        end
    end

    ost_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (acc.wr_hi),
        .load_val  ({wdata, lo_latch_q}),
        .cnt_o     (cnt),
        .timeout_o (timeout)
    );

    assign flag_clr = acc.wr_hi || acc.rd_lo || (acc.wr_flag && wdata[FLAG_BIT]);

    ost_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_i   (timeout),
        .clr_i   (flag_clr),
        .ena_wr  (acc.wr_ena && wdata[ENA_SEL_BIT]),
        .ena_val (wdata[ENA_MODE_BIT]),
        .flag_o  (flag),
        .ena_o   (ena),
        .irq_o   (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (ost_reg_e'(addr))
            REG_CNT_LO: rdata = cnt[BYTE_W-1:0];
            REG_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
            REG_FLAG: begin
                rdata[FLAG_BIT]     = flag;
                rdata[IRQ_VIEW_BIT] = irq;
            end
            REG_ENA:    rdata[ENA_SEL_BIT] = ena;
            default:    rdata = '0;
        endcase
    end

    assign irq_o = irq;

    // R2: a low-byte write alone never disturbs the flag
    p_lo_write_flag_r2: assert property (@(posedge clk) disable iff (rst)
        acc.wr_lo && !timeout |=> flag == $past(flag));

    // R4: the flag only rises because of a timeout
    p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
        !flag && !timeout |=> !flag);

endmodule

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       wr_en;
    logic       rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] got;

    always #10 clk = ~clk;

    oneshot_timer #(.BYTE_W(8)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // each entry: {start value, number of ticks}
    localparam logic [31:0] VEC [12] = '{
        {16'd5,   16'd0},
        {16'd5,   16'd1},
        {16'd5,   16'd3},
        {16'd5,   16'd6},
        {16'd5,   16'd7},
        {16'd5,   16'd20},
        {16'd0,   16'd1},
        {16'd0,   16'd2},
        {16'd0,   16'd5},
        {16'd1,   16'd3},
        {16'd300, 16'd10},
        {16'd2,   16'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called and returning at a falling edge
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic bus_rd_strobe(input logic [1:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #2;
        v = rdata;
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        peek(2'd0, lo);
        peek(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        bus_wr(2'd0, v[7:0]);
        bus_wr(2'd1, v[15:8]);
    endtask

    function automatic int flag_now();
        return int'(rdata[0]);
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = 2'd0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        read_cnt(got); chk("R1 counter", int'(got), 0);
        peek(2'd2, b);  chk("R1 flag", int'(b[0]), 0);
        peek(2'd3, b);  chk("R1 enable", int'(b[0]), 0);
        chk("R1 irq", int'(irq_o), 0);
        ticks(3);
        read_cnt(got); chk("R1 free count", int'(got), 16'hFFFD);
        peek(2'd2, b);  chk("R1 disarmed wrap no flag", int'(b[0]), 0);

        // table walk: R3 R4 R5
        foreach (VEC[i]) begin
            int n;
            int t;
            int exp_c;
            int exp_f;
            n = int'(VEC[i][31:16]);
            t = int'(VEC[i][15:0]);
            load(VEC[i][31:16]);
            ticks(t);
            exp_c = (t == 0) ? n : ((n - (t - 1)) & 16'hFFFF);
            exp_f = (t >= n + 2) ? 1 : 0;
            read_cnt(got);
            chk("R3/R5 table count", int'(got), exp_c);
            peek(2'd2, b);
            chk("R4 table flag", int'(b[0]), exp_f);
        end

        // R2: low write leaves counter alone
        load(16'h1234);
        bus_wr(2'd0, 8'hAB);
        read_cnt(got); chk("R2 low write no load", int'(got), 16'h1234);
        bus_wr(2'd1, 8'h0C);
        read_cnt(got); chk("R2 high write loads", int'(got), 16'h0CAB);

        // R3: load coinciding with a tick
        tick = 1'b1;
        bus_wr(2'd1, 8'h00);
        tick = 1'b0;
        read_cnt(got); chk("R3 load wins over tick", int'(got), 16'h00AB);
        ticks(1);
        read_cnt(got); chk("R3 hold after tick-load", int'(got), 16'h00AB);
        ticks(1);
        read_cnt(got); chk("R3 step", int'(got), 16'h00AA);

        // R6: full wrap without second flag
        load(16'h0000);
        ticks(2);
        peek(2'd2, b); chk("R6 first flag", int'(b[0]), 1);
        bus_wr(2'd2, 8'h01);
        peek(2'd2, b); chk("R9 write-one clear", int'(b[0]), 0);
        ticks(65536);
        read_cnt(got); chk("R5 full wrap", int'(got), 16'hFFFF);
        peek(2'd2, b); chk("R6 no second flag", int'(b[0]), 0);
        load(16'h0003);
        ticks(4);
        peek(2'd2, b); chk("R6 rearm before timeout", int'(b[0]), 0);
        ticks(1);
        peek(2'd2, b); chk("R6 rearm fires", int'(b[0]), 1);

        // R7 / R8 masking
        chk("R7 flag while masked, irq low", int'(irq_o), 0);
        peek(2'd2, b); chk("R8 irq view masked", int'(b[7]), 0);
        bus_wr(2'd3, 8'h80);
        peek(2'd3, b); chk("R8 no-select write ignored", int'(b[0]), 0);
        bus_wr(2'd3, 8'h81);
        chk("R8 irq enabled", int'(irq_o), 1);
        peek(2'd2, b); chk("R8 irq view", int'(b[7]), 1);
        bus_wr(2'd3, 8'h00);
        chk("R8 no-select clear ignored", int'(irq_o), 1);
        bus_wr(2'd3, 8'h01);
        chk("R8 enable cleared", int'(irq_o), 0);
        peek(2'd2, b); chk("R7 flag held", int'(b[0]), 1);

        // R9 clears
        bus_wr(2'd2, 8'h00);
        peek(2'd2, b); chk("R9 write-zero keeps flag", int'(b[0]), 1);
        bus_rd_strobe(2'd0);
        peek(2'd2, b); chk("R9 read-low clears", int'(b[0]), 0);
        load(16'h0000);
        ticks(2);
        peek(2'd2, b); chk("R4 flag for reload", int'(b[0]), 1);
        load(16'h0010);
        peek(2'd2, b); chk("R2 load clears flag", int'(b[0]), 0);

        // R9: timeout beats a same-cycle clear
        load(16'h0000);
        ticks(1);
        tick = 1'b1; rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        peek(2'd2, b); chk("R9 set wins over clear", int'(b[0]), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule